// File: doc/BRIEF.md
# UART receiver with status flags

This block is the receive half of an asynchronous serial port with a small register file on a synchronous bus. The serial input passes through a synchronizer and is sampled on a tick that runs at sixteen times the bit rate. The tick comes from a programmable 13-bit divisor. Each bit is decided by a majority vote over three samples near the middle of the bit. A finished character lands in a read-only data register and sets a data-ready flag. An optional parity check and a stop-bit check flag errors. A character that arrives while the previous one is still unread is dropped, and the overrun flag is raised.

Software configures character length, parity and enables through a control register, then polls the status register or waits for the interrupt request. Both flags clear through a fixed handshake: a status read that observes the data-ready flag, followed by a data read. The upper divisor bits are staged and take effect only when the low byte is written, so the rate never passes through a half-updated value.

Top module: `uart_rx_regs`

## Requirements
- R1: After reset the control, divisor, status and data registers read 0 and `irq` is low.
- R2: A frame is one low start bit, 8 data bits sent LSB first, optional parity, and one stop bit, each lasting 16 ticks. On completion the character appears in DATA (address 4) bits [7:0] and the data-ready flag, STATUS (address 3) bit 0, is set.
- R3: With CTRL (address 0) bit 1 set, frames carry 9 data bits, and the ninth appears in DATA bit 8. In 8-bit mode DATA bit 8 reads 0.
- R4: With CTRL bit 2 set, a parity bit follows the last data bit. CTRL bit 3 selects odd parity (1) or even parity (0). A mismatch sets STATUS bit 3.
- R5: A stop bit sampled low sets STATUS bit 2.
- R6: If a character completes while the data-ready flag is set, STATUS bit 1 (overrun) is set, and DATA keeps the earlier character.
- R7: A DATA read clears the data-ready, overrun and both error flags only if a STATUS read that saw the data-ready flag set came before it. A DATA read without that STATUS read leaves the flags unchanged.
- R8: `irq` is high exactly when CTRL bit 4 is 1 and the data-ready or overrun flag is set.
- R9: A write to DIV_HI (address 1, bits [4:0]) is staged. Both divisor halves take effect together on a write to DIV_LO (address 2, bits [7:0]). Reads of both addresses return the divisor in use.
- R10: While the divisor is 0 no tick is generated and no character is received.
- R11: While CTRL bit 0 (receive enable) is 0 the receiver stays idle and no character is received.
- R12: A low pulse that is gone by the middle of the start bit is rejected as a false start.
- R13: If a character completes in the same cycle as a clearing DATA read, the read returns the old character. The new character is then accepted, the data-ready flag stays set, and no overrun is raised.
- R14: Register reads return their value on `rdata` in the cycle after the `rd` strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Asynchronous serial receive line, idle high |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| rdata | output | 16 | Registered read data |
| irq | output | 1 | Receive interrupt request |

## Verification
Two events can land in the same cycle: completion of an incoming character, and the DATA read that finishes the clear handshake for the previous one. The bench sets the divisor to 1 so that a tick occurs on every clock. The completion cycle then follows exactly from the start-bit edge, and the bench places the clearing read on that cycle. It judges the outcome at the ports: the read must return the old character, and STATUS must then show data-ready without overrun, with the new character readable.

// File: rtl/urx_pkg.sv
package urx_pkg;

    localparam int CHW = 9;

    typedef enum logic [2:0] {
        A_CTRL = 3'd0,
        A_DIVH = 3'd1,
        A_DIVL = 3'd2,
        A_STAT = 3'd3,
        A_DATA = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic irq_en;
        logic par_odd;
        logic par_en;
        logic nine;
        logic rx_en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP
    } rx_state_e;

    typedef struct packed {
        logic [CHW-1:0] chr;
        logic           perr;
        logic           ferr;
    } frame_t;

    function automatic logic vote3(input logic [2:0] v);
        return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
    endfunction

endpackage

// File: rtl/urx_sync.sv
module urx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic ff [STAGES];

    always_ff @(posedge clk) begin
        if (rst) ff[0] <= 1'b1;
        else     ff[0] <= d;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) ff[g] <= 1'b1;
                else     ff[g] <= ff[g-1];
            end
        end
    endgenerate

    assign q = ff[STAGES-1];
endmodule

// File: rtl/urx_baud.sv
module urx_baud #(
    parameter int DIV_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic             run;

    assign run  = (div != '0);
    assign tick = run && (cnt == div - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || restart || !run) cnt <= '0;
        else if (tick)              cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/urx_frame.sv
module urx_frame
    import urx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  logic   tick,
    input  logic   rxd,
    input  logic   nine,
    input  logic   par_en,
    input  logic   par_odd,
    output logic   done,
    output frame_t frm
);
    localparam int            SW      = $clog2(OVS);
    localparam logic [SW-1:0] SMP_A   = SW'(OVS/2 - 1);
    localparam logic [SW-1:0] SMP_B   = SW'(OVS/2);
    localparam logic [SW-1:0] SMP_C   = SW'(OVS/2 + 1);
    localparam logic [SW-1:0] SMP_END = SW'(OVS - 1);

    rx_state_e      st;
    logic [SW-1:0]  s;
    logic [1:0]     v;
    logic [3:0]     idx;
    logic [CHW-1:0] sh;
    logic           pbit;

    logic           bitv;
    logic [3:0]     last_idx;
    logic [CHW-1:0] used;
    logic           pexp;

    assign bitv     = vote3({rxd, v});
    assign last_idx = nine ? 4'd8 : 4'd7;
    assign used     = nine ? sh : {1'b0, sh[7:0]};
    assign pexp     = par_odd ? ~^used : ^used;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st   <= S_IDLE;
            s    <= '0;
            v    <= '0;
            idx  <= '0;
            sh   <= '0;
            pbit <= 1'b0;
            done <= 1'b0;
            frm  <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                if (st == S_IDLE) begin
                    if (!rxd) begin
                        st <= S_START;
                        s  <= SW'(1);
                        sh <= '0;
                    end
                end else begin
                    s <= (s == SMP_END) ? '0 : s + 1'b1;
                    if (s == SMP_A) v[0] <= rxd;
                    if (s == SMP_B) v[1] <= rxd;
                    if (s == SMP_C) begin
                        case (st)
                            S_START: if (bitv) st <= S_IDLE;
                            S_DATA:  sh[idx] <= bitv;
                            S_PAR:   pbit <= bitv;
                            S_STOP: begin
                                done     <= 1'b1;
                                frm.chr  <= used;
                                frm.perr <= par_en && (pbit != pexp);
                                frm.ferr <= !bitv;
                                st       <= S_IDLE;
                            end
                            default: ;
                        endcase
                    end
                    if (s == SMP_END) begin
                        case (st)
                            S_START: begin
                                st  <= S_DATA;
                                idx <= '0;
                            end
                            S_DATA: begin
                                if (idx == last_idx) st <= par_en ? S_PAR : S_STOP;
                                else                 idx <= idx + 1'b1;
                            end
                            S_PAR:   st <= S_STOP;
                            default: ;
                        endcase
                    end
                end
            end
        end
    end
endmodule

// File: rtl/uart_rx_regs.sv
module uart_rx_regs
    import urx_pkg::*;
#(
    parameter int DIV_W       = 13,
    parameter int DW          = 16,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_i,
    input  logic [2:0]    addr,
    input  logic [DW-1:0] wdata,
    input  logic          wr,
    input  logic          rd,
    output logic [DW-1:0] rdata,
    output logic          irq
);
    localparam int HI_W = DIV_W - 8;

    ctrl_t            ctrl_q;
    logic [HI_W-1:0]  div_stage;
    logic [DIV_W-1:0] div_q;
    logic             commit;
    logic             tick;
    logic             rx_s;
    logic             done;
    frame_t           frm;

    logic [CHW-1:0]   data_q;
    logic             full, ovr, fe, pe, armed;
    logic             clr, wr_divh, rx_en, irq_en;

    assign rx_en   = ctrl_q.rx_en;
    assign irq_en  = ctrl_q.irq_en;
    assign commit  = wr && (addr == A_DIVL);
    assign wr_divh = wr && (addr == A_DIVH);
    assign clr     = rd && (addr == A_DATA) && armed;

    urx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (rx_i),
        .q   (rx_s)
    );

    urx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk     (clk),
        .rst     (rst),
        .restart (commit),
        .div     (div_q),
        .tick    (tick)
    );

    urx_frame #(.OVS(OVS)) u_frame (
        .clk     (clk),
        .rst     (rst),
        .en      (rx_en),
        .tick    (tick),
        .rxd     (rx_s),
        .nine    (ctrl_q.nine),
        .par_en  (ctrl_q.par_en),
        .par_odd (ctrl_q.par_odd),
        .done    (done),
        .frm     (frm)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            div_stage <= '0;
            div_q     <= '0;
        end else if (wr) begin
            case (addr)
                A_CTRL:  ctrl_q    <= ctrl_t'(wdata[CTRL_W-1:0]);
                A_DIVH:  div_stage <= wdata[HI_W-1:0];
                A_DIVL:  div_q     <= {div_stage, wdata[7:0]};
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            full   <= 1'b0;
            ovr    <= 1'b0;
            fe     <= 1'b0;
            pe     <= 1'b0;
            armed  <= 1'b0;
        end else begin
            if (rd && (addr == A_STAT) && full) armed <= 1'b1;
            if (clr) begin
                full  <= 1'b0;
                ovr   <= 1'b0;
                fe    <= 1'b0;
                pe    <= 1'b0;
                armed <= 1'b0;
            end
            if (done) begin
                if (full && !clr) begin
                    ovr <= 1'b1;
                end else begin
                    data_q <= frm.chr;
                    fe     <= frm.ferr;
                    pe     <= frm.perr;
                    full   <= 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd) begin
            case (addr)
                A_CTRL:  rdata <= DW'(ctrl_q);
                A_DIVH:  rdata <= DW'(div_q[DIV_W-1:8]);
                A_DIVL:  rdata <= DW'(div_q[7:0]);
                A_STAT:  rdata <= DW'({pe, fe, ovr, full});
                A_DATA:  rdata <= DW'(data_q);
                default: rdata <= '0;
            endcase
        end
    end

    assign irq = irq_en && (full || ovr);
endmodule

// File: rtl/urx_checker.sv
module urx_checker #(
    parameter int DIV_W = 13
) (
    input logic             clk,
    input logic             rst,
    input logic             irq,
    input logic             irq_en,
    input logic             full,
    input logic             ovr,
    input logic             done,
    input logic             clr,
    input logic [8:0]       data_q,
    input logic [DIV_W-1:0] div_q,
    input logic             wr_divh,
    input logic             tick,
    input logic             rx_en
);
    p_irq_on_r8: assert property (@(posedge clk) disable iff (rst)
        (irq_en && full) |-> irq);

    p_irq_off_r8: assert property (@(posedge clk) disable iff (rst)
        (!full && !ovr) |-> !irq);

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        (done && !full) |=> full);

    p_keep_r6: assert property (@(posedge clk) disable iff (rst)
        (done && full && !clr) |=> (ovr && data_q == $past(data_q)));

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (full && !clr) |=> full);

    p_stage_r9: assert property (@(posedge clk) disable iff (rst)
        wr_divh |=> (div_q == $past(div_q)));

    p_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (div_q == '0) |-> !tick);

    p_off_r11: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> !done);

    p_collide_r13: assert property (@(posedge clk) disable iff (rst)
        (clr && done) |=> (full && !ovr));
endmodule

bind uart_rx_regs urx_checker chk_i (
    .clk     (clk),
    .rst     (rst),
    .irq     (irq),
    .irq_en  (irq_en),
    .full    (full),
    .ovr     (ovr),
    .done    (done),
    .clr     (clr),
    .data_q  (data_q),
    .div_q   (div_q),
    .wr_divh (wr_divh),
    .tick    (tick),
    .rx_en   (rx_en)
);

// File: tb/uart_rx_regs_tb_top.sv
`timescale 1ns/1ps
module uart_rx_regs_tb_top;
    localparam logic [2:0] CTRL = 3'd0, DIVH = 3'd1, DIVL = 3'd2, STAT = 3'd3, DATA = 3'd4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_i = 1'b1;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [15:0] rdata;
    logic        irq;

    int n_vec = 0;
    int n_bad = 0;

    typedef struct {
        logic [15:0] data;
        logic [15:0] stat;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    uart_rx_regs dut_i (
        .clk   (clk),
        .rst   (rst),
        .rx_i  (rx_i),
        .addr  (addr),
        .wdata (wdata),
        .wr    (wr),
        .rd    (rd),
        .rdata (rdata),
        .irq   (irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        v = rdata;
    endtask

    function automatic logic par_of(input logic [8:0] ch, input int nb, input bit odd);
        logic p = 1'b0;
        for (int i = 0; i < nb; i++) p ^= ch[i];
        return odd ? ~p : p;
    endfunction

    // Drives a frame starting at the current time; caller sits on a negedge.
    task automatic send_frame(input logic [8:0] ch, input int nb, input bit par_on,
                              input bit pbit, input bit stop_low, input int bl);
        rx_i = 1'b0;
        repeat (bl) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            rx_i = ch[i];
            repeat (bl) @(negedge clk);
        end
        if (par_on) begin
            rx_i = pbit;
            repeat (bl) @(negedge clk);
        end
        if (stop_low) begin
            rx_i = 1'b0;
            repeat (bl * 3 / 4) @(negedge clk);
            rx_i = 1'b1;
            repeat (bl / 4) @(negedge clk);
        end else begin
            rx_i = 1'b1;
            repeat (bl) @(negedge clk);
        end
        rx_i = 1'b1;
        repeat (bl) @(negedge clk);
    endtask

    // Driver: records the expected register contents, then drives the line.
    task automatic drive(input logic [8:0] ch, input int nb, input bit par_on,
                         input bit pbit, input bit stop_low, input int bl,
                         input logic [15:0] stat);
        exp_t e;
        e.data = (nb == 9) ? {7'd0, ch} : {8'd0, ch[7:0]};
        e.stat = stat;
        exp_q.push_back(e);
        @(negedge clk);
        send_frame(ch, nb, par_on, pbit, stop_low, bl);
    endtask

    // Monitor: pops the oldest expectation and compares it with the registers.
    task automatic collect(input string req);
        exp_t e;
        logic [15:0] v;
        if (exp_q.size() == 0) begin
            check({req, " queue"}, 16'hdead, 16'h0000);
            return;
        end
        e = exp_q.pop_front();
        bus_read(STAT, v);
        check({req, " status"}, v, e.stat);
        bus_read(DATA, v);
        check({req, " data"}, v, e.data);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        bus_read(STAT, v); check("R1 status", v, 16'h0000);
        bus_read(CTRL, v); check("R1 ctrl", v, 16'h0000);
        bus_read(DIVL, v); check("R1 divlo", v, 16'h0000);
        bus_read(DATA, v); check("R1 data", v, 16'h0000);
        check("R1 irq", {15'd0, irq}, 16'h0000);

        // R10 zero divisor: enabled receiver but no tick
        bus_write(CTRL, 16'h0001);
        @(negedge clk);
        send_frame(9'h055, 8, 1'b0, 1'b0, 1'b0, 32);
        bus_read(STAT, v); check("R10 no char", v, 16'h0000);

        // R9 staging of the upper divisor bits
        bus_write(DIVH, 16'h0001);
        bus_read(DIVH, v); check("R9 hi staged", v, 16'h0000);
        bus_write(DIVL, 16'h0002);
        bus_read(DIVH, v); check("R9 hi commit", v, 16'h0001);
        bus_read(DIVL, v); check("R9 lo commit", v, 16'h0002);
        bus_write(DIVH, 16'h0000);
        bus_write(DIVL, 16'h0002);
        bus_read(DIVH, v); check("R9 hi back", v, 16'h0000);

        // R2 / R8 basic 8-bit reception with interrupt
        bus_write(CTRL, 16'h0011);
        check("R8 irq idle", {15'd0, irq}, 16'h0000);
        drive(9'h0A5, 8, 1'b0, 1'b0, 1'b0, 32, 16'h0001);
        check("R8 irq full", {15'd0, irq}, 16'h0001);
        collect("R2 0xA5");
        check("R8 irq cleared", {15'd0, irq}, 16'h0000);
        drive(9'h03C, 8, 1'b0, 1'b0, 1'b0, 32, 16'h0001);
        collect("R2 0x3C");

        // R11 receiver disabled
        bus_write(CTRL, 16'h0010);
        @(negedge clk);
        send_frame(9'h0C3, 8, 1'b0, 1'b0, 1'b0, 32);
        bus_read(STAT, v); check("R11 disabled", v, 16'h0000);
        bus_write(CTRL, 16'h0011);

        // R7 clear handshake
        @(negedge clk);
        send_frame(9'h03C, 8, 1'b0, 1'b0, 1'b0, 32);
        bus_read(DATA, v); check("R7 data only", v, 16'h003C);
        bus_read(STAT, v); check("R7 still full", v, 16'h0001);
        bus_read(DATA, v); check("R7 data", v, 16'h003C);
        bus_read(STAT, v); check("R7 cleared", v, 16'h0000);
        @(negedge clk);
        send_frame(9'h081, 8, 1'b0, 1'b0, 1'b0, 32);
        bus_read(DATA, v); check("R7 unarmed read", v, 16'h0081);
        bus_read(STAT, v); check("R7 stale arm ignored", v, 16'h0001);
        bus_read(DATA, v);
        bus_read(STAT, v); check("R7 cleared again", v, 16'h0000);

        // R6 overrun keeps the first character
        @(negedge clk);
        send_frame(9'h011, 8, 1'b0, 1'b0, 1'b0, 32);
        @(negedge clk);
        send_frame(9'h022, 8, 1'b0, 1'b0, 1'b0, 32);
        check("R8 irq overrun", {15'd0, irq}, 16'h0001);
        bus_write(CTRL, 16'h0001);
        check("R8 irq masked", {15'd0, irq}, 16'h0000);
        bus_read(STAT, v); check("R6 flags", v, 16'h0003);
        bus_read(DATA, v); check("R6 first kept", v, 16'h0011);
        bus_read(STAT, v); check("R6 cleared", v, 16'h0000);

        // R3 nine-bit characters
        bus_write(CTRL, 16'h0003);
        drive(9'h1C3, 9, 1'b0, 1'b0, 1'b0, 32, 16'h0001);
        collect("R3 0x1C3");
        drive(9'h0A0, 9, 1'b0, 1'b0, 1'b0, 32, 16'h0001);
        collect("R3 0x0A0");

        // R4 parity, even then odd
        bus_write(CTRL, 16'h0005);
        drive(9'h05A, 8, 1'b1, par_of(9'h05A, 8, 1'b0), 1'b0, 32, 16'h0001);
        collect("R4 even ok");
        drive(9'h05A, 8, 1'b1, ~par_of(9'h05A, 8, 1'b0), 1'b0, 32, 16'h0009);
        collect("R4 even bad");
        bus_write(CTRL, 16'h000D);
        drive(9'h007, 8, 1'b1, par_of(9'h007, 8, 1'b1), 1'b0, 32, 16'h0001);
        collect("R4 odd ok");
        drive(9'h007, 8, 1'b1, ~par_of(9'h007, 8, 1'b1), 1'b0, 32, 16'h0009);
        collect("R4 odd bad");
        bus_write(CTRL, 16'h0007);
        drive(9'h100, 9, 1'b1, par_of(9'h100, 9, 1'b0), 1'b0, 32, 16'h0001);
        collect("R4 nine even");

        // R5 framing error
        bus_write(CTRL, 16'h0001);
        drive(9'h066, 8, 1'b0, 1'b0, 1'b1, 32, 16'h0005);
        collect("R5 low stop");
        bus_read(STAT, v); check("R5 cleared", v, 16'h0000);

        // R12 short low glitch
        @(negedge clk);
        rx_i = 1'b0;
        repeat (8) @(negedge clk);
        rx_i = 1'b1;
        repeat (400) @(negedge clk);
        bus_read(STAT, v); check("R12 glitch", v, 16'h0000);
        drive(9'h04D, 8, 1'b0, 1'b0, 1'b0, 32, 16'h0001);
        collect("R12 after glitch");

        // R13 completion in the clearing-read cycle, divisor 1
        bus_write(DIVL, 16'h0001);
        @(negedge clk);
        send_frame(9'h03A, 8, 1'b0, 1'b0, 1'b0, 16);
        bus_read(STAT, v); check("R13 armed", v, 16'h0001);
        @(negedge clk);
        fork
            send_frame(9'h0C5, 8, 1'b0, 1'b0, 1'b0, 16);
            begin
                repeat (156) @(negedge clk);
                addr = DATA; rd = 1'b1;
                @(negedge clk);
                rd = 1'b0;
                // R14 the value is present in the cycle after the strobe
                check("R13 R14 old char", rdata, 16'h003A);
            end
        join
        bus_read(STAT, v); check("R13 no overrun", v, 16'h0001);
        bus_read(DATA, v); check("R13 new char", v, 16'h00C5);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule